// File: doc/BRIEF.md
# Retention-Binned Row Refresh Scheduler

This block decides, row by row, whether a DRAM row needs a refresh in the current base period. Short-retention rows are refreshed more often than the rest. Two hardware Bloom filters hold the retention bins:

- the short bin, for rows that hold data 64 to 128 ms;
- the medium bin, for rows that hold data 128 to 256 ms.

A programming port inserts row addresses into either filter. A clear input empties both filters. Each filter position is picked by a one-cycle XOR hash: row-address bits are XORed under a constant matrix that is fixed for each hash.

A free-running timer divides time into base periods, each standing for 64 ms, and counts a period index from 0 to 3. At the start of every base period the sweep walks the whole row space in ascending order and probes both filters for each row:

- A short-bin hit is refreshed in every period.
- A medium-bin hit is refreshed only in periods 0 and 2.
- Every other row is refreshed only in period 0, which gives the default 256 ms interval.

The short filter is consulted first. A false positive only makes a row refresh more often than it needs to, and an inserted row can never be missed.

Refresh requests leave through a valid/ready port that carries the row address and the bin code. The command layer turns each accepted request into an activate followed by a precharge of that row.

Top module: `rfb_refresh_sched`

## Requirements
- R1: After reset both filters are empty, the period index is 0 and `req_valid` is low.
- R2: In every period-0 sweep each row of the row space is requested exactly once, in strictly ascending row order.
- R3: A row that is in neither filter is requested only in period 0, with bin code 2 (default).
- R4: A row inserted into the short filter (`ins_bin`=0) is requested exactly once in each of the four periods, with bin code 0.
- R5: A row inserted into the medium filter (`ins_bin`=1) is requested once in period 0 and once in period 2, with bin code 0 or 1.
- R6: Bins are tested shortest first: a row present in both filters reports bin code 0.
- R7: A probe of a row that was inserted on the previous cycle reports a hit, so a row is never refreshed less often than its bin requires.
- R8: A `clr` pulse empties both filters and takes priority over an insert in the same cycle. After it, only period-0 requests remain.
- R9: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_row` and `req_bin` hold their values.
- R10: A cycle with `ins_valid` high stalls the sweep, so the sweep skips no row and repeats no row.
- R11: The period index advances by one, modulo 4, every `PERIOD_CYCLES` clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Empties both filters |
| ins_valid | input | 1 | Insert strobe |
| ins_bin | input | 1 | Target filter: 0 short, 1 medium |
| ins_row | input | ROW_W | Row address to insert |
| req_valid | output | 1 | Refresh request present |
| req_ready | input | 1 | Command layer accepts the request |
| req_row | output | ROW_W | Row to activate and precharge |
| req_bin | output | 2 | Bin code: 0 short, 1 medium, 2 default |

## Verification
The bench builds the block with a 16-row space (`ROW_W`=4) and a 96-cycle base period, so a full four-period cycle takes only 384 cycles. This lets the bench observe, in a short run, every period phase for short, medium, dual-bin and default rows.

The filters are shrunk to 64 and 128 bits with 3 and 2 hashes. At that size aliasing between rows is likely, so false positives really occur; for the rows it programmed, the bench therefore checks lower bounds and never exact counts. The bench also gates `req_ready` pseudo-randomly and times inserts to land in the middle of a sweep, which exercises both stall paths.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

    typedef enum logic [1:0] {
        BIN_SHORT   = 2'd0,
        BIN_MED     = 2'd1,
        BIN_DEFAULT = 2'd2
    } rbin_e;

    typedef struct packed {
        logic  hit_short;
        logic  hit_med;
    } probe_t;

    localparam int PERIOD_PHASES = 4;

    // Constant matrix entry for hash h, address bit b: integer mixing of (h, b, seed).
    function automatic logic [31:0] h3_word(input int h, input int b, input int seed);
        logic [31:0] x;
        x = 32'(h) * 32'd40503 + 32'(b) * 32'h9E37_79B1 + 32'(seed) * 32'h85EB_CA6B + 32'h27D4_EB2F;
        x = x ^ (x >> 15);
        x = x * 32'h2C1B_3C6D;
        x = x ^ (x >> 12);
        x = x * 32'h297A_2D39;
        x = x ^ (x >> 15);
        return x;
    endfunction

    function automatic rbin_e pick_bin(input probe_t p);
        if (p.hit_short)    return BIN_SHORT;
        else if (p.hit_med) return BIN_MED;
        else                return BIN_DEFAULT;
    endfunction

    function automatic logic bin_due(input rbin_e b, input logic [1:0] phase);
        case (b)
            BIN_SHORT: return 1'b1;
            BIN_MED:   return ~phase[0];
            default:   return (phase == 2'd0);
        endcase
    endfunction

endpackage

// File: rtl/rfb_hash_bank.sv
module rfb_hash_bank #(
    parameter int ROW_W    = 16,
    parameter int IDX_W    = 11,
    parameter int NUM_HASH = 10,
    parameter int SEED     = 1
) (
    input  logic [ROW_W-1:0]          row,
    output logic [NUM_HASH*IDX_W-1:0] idx
);

    for (genvar h = 0; h < NUM_HASH; h++) begin : g_hash
        logic [IDX_W-1:0] acc;
        always_comb begin
            acc = '0;
            for (int b = 0; b < ROW_W; b++) begin
                if (row[b]) acc = acc ^ IDX_W'(rfb_pkg::h3_word(h, b, SEED));
            end
        end
        assign idx[h*IDX_W +: IDX_W] = acc;
    end

endmodule

// File: rtl/rfb_bloom.sv
module rfb_bloom #(
    parameter int ROW_W    = 16,
    parameter int NBITS    = 2048,
    parameter int NUM_HASH = 10,
    parameter int SEED     = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ins_en,
    input  logic [ROW_W-1:0] ins_row,
    input  logic [ROW_W-1:0] probe_row,
    output logic             probe_hit
);

    localparam int IDX_W = $clog2(NBITS);

    logic [NBITS-1:0]          bits_q;
    logic [NUM_HASH*IDX_W-1:0] ins_idx;
    logic [NUM_HASH*IDX_W-1:0] prb_idx;

    rfb_hash_bank #(.ROW_W(ROW_W), .IDX_W(IDX_W), .NUM_HASH(NUM_HASH), .SEED(SEED)) u_ins_hash (
        .row (ins_row),
        .idx (ins_idx)
    );

    rfb_hash_bank #(.ROW_W(ROW_W), .IDX_W(IDX_W), .NUM_HASH(NUM_HASH), .SEED(SEED)) u_prb_hash (
        .row (probe_row),
        .idx (prb_idx)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bits_q <= '0;
        end else if (ins_en) begin
            for (int h = 0; h < NUM_HASH; h++) begin
                bits_q[prb_sel(ins_idx, h)] <= 1'b1;
            end
        end
    end

    function automatic logic [IDX_W-1:0] prb_sel(input logic [NUM_HASH*IDX_W-1:0] v, input int h);
        return v[h*IDX_W +: IDX_W];
    endfunction

    always_comb begin
        probe_hit = 1'b1;
        for (int h = 0; h < NUM_HASH; h++) begin
            probe_hit = probe_hit & bits_q[prb_sel(prb_idx, h)];
        end
    end

    AST_INSERT_HITS: assert property (@(posedge clk) disable iff (rst)
        ($past(ins_en && !clr && !rst) && probe_row == $past(ins_row)) |-> probe_hit); // R7

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(clr && !rst) |-> !probe_hit); // R8

endmodule

// File: rtl/rfb_period_timer.sv
module rfb_period_timer #(
    parameter int PERIOD_CYCLES = 4_000_000
) (
    input  logic       clk,
    input  logic       rst,
    output logic [1:0] phase,
    output logic       tick
);

    localparam int CNT_W = (PERIOD_CYCLES > 2) ? $clog2(PERIOD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYCLES - 1);

    logic [CNT_W-1:0] tmr_q;

    assign tick = (tmr_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
            phase <= 2'd0;
        end else if (tick) begin
            tmr_q <= '0;
            phase <= phase + 2'd1;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    AST_PERIOD_ADV: assert property (@(posedge clk) disable iff (rst)
        tick |=> phase == $past(phase) + 2'd1); // R11

    AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(phase)); // R11

endmodule

// File: rtl/rfb_refresh_sched.sv
module rfb_refresh_sched #(
    parameter int ROW_W         = 16,
    parameter int SHORT_BITS    = 2048,
    parameter int SHORT_HASH    = 10,
    parameter int MED_BITS      = 8192,
    parameter int MED_HASH      = 6,
    parameter int PERIOD_CYCLES = 4_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ins_valid,
    input  logic             ins_bin,
    input  logic [ROW_W-1:0] ins_row,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [ROW_W-1:0] req_row,
    output logic [1:0]       req_bin
);
    import rfb_pkg::*;

    localparam logic [ROW_W-1:0] LAST_ROW = {ROW_W{1'b1}};

    logic [1:0]       phase;
    logic             tick;
    logic             running_q;
    logic             start_pend_q;
    logic [ROW_W-1:0] cur_q;
    probe_t           prb;
    rbin_e            bin_sel;
    rbin_e            out_bin_q;
    logic             due;
    logic             out_free;
    logic             step;

    rfb_period_timer #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .tick  (tick)
    );

    rfb_bloom #(.ROW_W(ROW_W), .NBITS(SHORT_BITS), .NUM_HASH(SHORT_HASH), .SEED(11)) u_short (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .ins_en    (ins_valid && !ins_bin),
        .ins_row   (ins_row),
        .probe_row (cur_q),
        .probe_hit (prb.hit_short)
    );

    rfb_bloom #(.ROW_W(ROW_W), .NBITS(MED_BITS), .NUM_HASH(MED_HASH), .SEED(23)) u_med (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .ins_en    (ins_valid && ins_bin),
        .ins_row   (ins_row),
        .probe_row (cur_q),
        .probe_hit (prb.hit_med)
    );

    assign bin_sel  = pick_bin(prb);
    assign due      = bin_due(bin_sel, phase);
    assign out_free = !req_valid || req_ready;
    assign step     = running_q && !ins_valid && out_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q    <= 1'b0;
            start_pend_q <= 1'b1;
            cur_q        <= '0;
            req_valid    <= 1'b0;
            req_row      <= '0;
            out_bin_q    <= BIN_DEFAULT;
        end else begin
            if (!running_q && start_pend_q) begin
                running_q    <= 1'b1;
                cur_q        <= '0;
                start_pend_q <= tick;
            end else if (tick) begin
                start_pend_q <= 1'b1;
            end

            if (step) begin
                cur_q <= cur_q + 1'b1;
                if (cur_q == LAST_ROW) running_q <= 1'b0;
                if (due) begin
                    req_valid <= 1'b1;
                    req_row   <= cur_q;
                    out_bin_q <= bin_sel;
                end else if (req_ready) begin
                    req_valid <= 1'b0;
                end
            end else if (req_valid && req_ready) begin
                req_valid <= 1'b0;
            end
        end
    end

    assign req_bin = out_bin_q;

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_row) && $stable(req_bin))); // R9

    AST_INS_STALL: assert property (@(posedge clk) disable iff (rst)
        (running_q && ins_valid) |=> $stable(cur_q)); // R10

    AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> cur_q == $past(cur_q) + 1'b1); // R2

    AST_BIN_CODE: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_bin != 2'd3); // R3

endmodule

// File: tb/sim_rfb_refresh_sched.sv
module sim_rfb_refresh_sched;

    localparam int CLK_PERIOD = 10;
    localparam int ROW_W      = 4;
    localparam int NROWS      = 1 << ROW_W;
    localparam int P          = 96;
    localparam int NTAB       = 6;
    // {bin, row}: bin 0 short, 1 medium
    localparam logic [4:0] INS_TAB [NTAB] = '{
        5'b0_0011, 5'b1_0101, 5'b0_1001, 5'b1_1100, 5'b1_0011, 5'b1_0000
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             clr = 1'b0;
    logic             ins_valid = 1'b0;
    logic             ins_bin = 1'b0;
    logic [ROW_W-1:0] ins_row = '0;
    logic             req_valid;
    logic             req_ready = 1'b1;
    logic [ROW_W-1:0] req_row;
    logic [1:0]       req_bin;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    logic logging = 1'b0;
    logic bp_on = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    int cnt [4][NROWS];
    int minbin [NROWS];
    int exp_bin [NROWS];
    int order_bad = 0;
    int last0 = -1;
    int hold_bad = 0;
    int stall_seen = 0;
    logic prev_stall = 1'b0;
    logic [ROW_W-1:0] prev_row = '0;
    logic [1:0] prev_bin = '0;

    rfb_refresh_sched #(
        .ROW_W(ROW_W), .SHORT_BITS(64), .SHORT_HASH(3),
        .MED_BITS(128), .MED_HASH(2), .PERIOD_CYCLES(P)
    ) u0 (
        .clk(clk), .rst(rst), .clr(clr), .ins_valid(ins_valid), .ins_bin(ins_bin),
        .ins_row(ins_row), .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .req_bin(req_bin)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (!rst) cyc <= cyc + 1;

    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            req_ready = bp_on ? lfsr[0] : 1'b1;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall && !(req_valid && req_row == prev_row && req_bin == prev_bin))
                hold_bad = hold_bad + 1;
            if (logging && req_valid && req_ready) begin
                int p;
                p = (cyc / P) % 4;
                cnt[p][req_row] = cnt[p][req_row] + 1;
                if (int'(req_bin) < minbin[req_row]) minbin[req_row] = int'(req_bin);
                if (p == 0) begin
                    if (int'(req_row) <= last0) order_bad = order_bad + 1;
                    last0 = int'(req_row);
                end
            end
            prev_stall = req_valid && !req_ready;
            prev_row   = req_row;
            prev_bin   = req_bin;
            if (prev_stall) stall_seen = stall_seen + 1;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_ins(input logic b, input logic [ROW_W-1:0] r);
        @(negedge clk);
        ins_valid = 1'b1;
        ins_bin   = b;
        ins_row   = r;
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic observe();
        do @(negedge clk); while (cyc % (4*P) != 0);
        for (int r = 0; r < NROWS; r++) begin
            for (int p = 0; p < 4; p++) cnt[p][r] = 0;
            minbin[r] = 3;
        end
        order_bad = 0;
        last0 = -1;
        logging = 1'b1;
        repeat (4*P) @(negedge clk);
        logging = 1'b0;
    endtask

    function automatic int sum_p(input int p);
        int s = 0;
        for (int r = 0; r < NROWS; r++) s += cnt[p][r];
        return s;
    endfunction

    task automatic check_empty_cycle(input string tag);
        int all_def = 1;
        for (int r = 0; r < NROWS; r++) if (cnt[0][r] != 1 || minbin[r] != 2) all_def = 0;
        check(sum_p(0) == NROWS && order_bad == 0, "R2 period-0 sweep complete and ascending", sum_p(0), NROWS);
        check(sum_p(1) + sum_p(2) + sum_p(3) == 0, {tag, " no requests outside period 0"},
              sum_p(1) + sum_p(2) + sum_p(3), 0);
        check(all_def == 1, "R3 every row once in period 0 with bin code 2", all_def, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < NROWS; r++) exp_bin[r] = 2;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(req_valid == 1'b0, "R1 req_valid low after reset", int'(req_valid), 0);

        // Empty filters: only period-0 refresh, default bin (R1, R3, R11)
        observe();
        check_empty_cycle("R3/R11 empty filters");

        // Table-driven inserts
        for (int i = 0; i < NTAB; i++) begin
            do_ins(INS_TAB[i][4], INS_TAB[i][3:0]);
            if (INS_TAB[i][4] == 1'b0) exp_bin[INS_TAB[i][3:0]] = 0;
            else if (exp_bin[INS_TAB[i][3:0]] == 2) exp_bin[INS_TAB[i][3:0]] = 1;
        end
        bp_on = 1'b1;
        observe();
        check(sum_p(0) == NROWS && order_bad == 0, "R2 period-0 sweep with backpressure", sum_p(0), NROWS);
        for (int r = 0; r < NROWS; r++) begin
            int mx = 0;
            for (int p = 0; p < 4; p++) if (cnt[p][r] > mx) mx = cnt[p][r];
            check(mx <= 1, "R2 at most one request per row per period", mx, 1);
            if (exp_bin[r] == 0) begin
                check(cnt[0][r] == 1 && cnt[1][r] == 1 && cnt[2][r] == 1 && cnt[3][r] == 1,
                      "R4 short row refreshed every period (R7, R11)", cnt[1][r] + cnt[3][r], 2);
                check(minbin[r] == 0, (r == 3) ? "R6 row in both filters reports short" : "R4 short bin code",
                      minbin[r], 0);
            end else if (exp_bin[r] == 1) begin
                check(cnt[0][r] == 1 && cnt[2][r] == 1, "R5 medium row refreshed in periods 0 and 2",
                      cnt[2][r], 1);
                check(minbin[r] <= 1, "R5 medium bin code", minbin[r], 1);
            end
        end
        check(hold_bad == 0, "R9 request held while not ready", hold_bad, 0);
        check(stall_seen > 0, "R9 backpressure exercised", stall_seen, 1);

        // R10: inserts land mid-sweep in period 0
        fork
            observe();
            begin
                do @(negedge clk); while (cyc % (4*P) != 5);
                do_ins(1'b0, 4'd14);
                do_ins(1'b1, 4'd7);
                do_ins(1'b0, 4'd14);
            end
        join
        check(sum_p(0) == NROWS && order_bad == 0, "R10 sweep stalled by inserts skips no row",
              sum_p(0), NROWS);
        check(cnt[1][14] == 1 && cnt[3][14] == 1, "R10 row inserted mid-sweep refreshed later periods",
              cnt[1][14] + cnt[3][14], 2);

        // R8: clear with a simultaneous insert
        @(negedge clk);
        clr = 1'b1;
        ins_valid = 1'b1;
        ins_bin = 1'b0;
        ins_row = 4'd7;
        @(negedge clk);
        clr = 1'b0;
        ins_valid = 1'b0;
        bp_on = 1'b0;
        observe();
        check_empty_cycle("R8 after clear");
        check(cnt[1][7] == 0, "R8 insert in clear cycle discarded", cnt[1][7], 0);
        check(hold_bad == 0, "R9 hold rule over whole run", hold_bad, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule